// File: doc/BRIEF.md
# Multi-mode byte timer channel

This block is one timer/counter channel of the kind found in small 8-bit controllers. It holds its count in two bytes, a low byte and a high byte. A two-bit mode field selects how the bytes count:

- a 13-bit timer, in which a 5-bit prescaler drives the high byte;
- a 16-bit cascade;
- an 8-bit counter that reloads itself from the high byte;
- a halt mode that freezes the count.

The count source is a single-cycle increment strobe. Counting can be made to depend on an external active-low gate pin, which is synchronised inside the block.

When the count rolls over, the block sets an overflow flag. Software reads and writes the two count bytes and a control byte through a small register port. The control byte holds the mode, run, gate-enable, flag, interrupt-enable and global-enable bits. The interrupt request is the flag qualified by both enables. A vector-acknowledge input clears the flag once the interrupt is taken.

Top module: `tmr_unit`

## Requirements
- R1: After reset, both count bytes and the control byte read 0 and `irq` is low.
- R2: Mode 0 (prescaled). Bits [4:0] of the low byte count the strobes and wrap from 31 to 0. Each wrap increments the high byte. Bits [7:5] of the low byte never change through counting. A wrap while the high byte is 0xFF sets the flag.
- R3: Mode 1 (cascade). {high, low} is one 16-bit counter. Stepping from 0xFFFF to 0x0000 sets the flag.
- R4: Mode 2 (reload). The low byte counts. When it steps from 0xFF, it loads the high byte's value and the flag is set. Counting never changes the high byte.
- R5: Mode 3 (halt). The count holds whatever the run bit and the strobe do.
- R6: With gate-enable 0, the run bit alone enables counting. With gate-enable 1, the gate pin must also be low, seen through a two-flop synchroniser: a pin change first affects a strobe sampled at the third rising edge after the change.
- R7: Each cycle in which `tick` is high and counting is enabled advances the count by exactly one. With run at 0, strobes have no effect.
- R8: An overflow sets the flag, and `vec_ack` clears it. If both happen in the same cycle, the set wins.
- R9: `irq` is high exactly when the flag, the interrupt-enable bit and the global-enable bit are all 1.
- R10: A software write to a count byte takes priority over a strobe in the same cycle. The strobe is dropped and the written value is loaded.
- R11: A write to the control byte loads the flag from data bit 4. An overflow in the same cycle sets the flag regardless of the written value.
- R12: Register map:
  - address 0: low byte.
  - address 1: high byte.
  - address 2: control byte. Bits [1:0] are the mode, bit 2 is run, bit 3 is gate-enable, bit 4 is the flag, bit 5 is the interrupt-enable and bit 6 is the global-enable. Bit 7 reads 0.
  - address 3: reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle increment strobe |
| gate_n | input | 1 | Asynchronous active-low external gate pin |
| vec_ack | input | 1 | Interrupt vector acknowledge, clears the flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
A strobe or register write applied before a rising edge shows its result on `rdata` and `irq` right after that same edge. The count, the flag and the request all update in one register stage, and `rdata` is a combinational read of the stored state. A gate pin change takes two further edges to reach the enable, so the first strobe that sees it is the one at the third edge.

The bench drives inputs at the falling edge. Its behavioural model advances on the rising edge, and model and design are compared a quarter period after every rising edge. Directed checks sample `rdata` one time unit after the falling edge that follows the stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TM_PRESCALED = 2'd0,
      TM_CASCADE   = 2'd1,
      TM_RELOAD    = 2'd2,
      TM_HALT      = 2'd3
   } tmr_mode_e;

   // register addresses
   localparam int unsigned RA_LOW  = 0;
   localparam int unsigned RA_HIGH = 1;
   localparam int unsigned RA_CTL  = 2;

   // control byte bit positions
   localparam int unsigned CB_MODE = 0;
   localparam int unsigned CB_RUN  = 2;
   localparam int unsigned CB_GATE = 3;
   localparam int unsigned CB_FLAG = 4;
   localparam int unsigned CB_IE   = 5;
   localparam int unsigned CB_EA   = 6;
endpackage

// File: rtl/tmr_gate_sync.sv
module tmr_gate_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic active
);
   localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_gate_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[i] <= IDLE_LVL;
         else if (i == 0) stage_q[i] <= pin;
         else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
   end

   if (ACTIVE_LOW) begin : g_act_low
      assign active = ~stage_q[STAGES-1];
   end else begin : g_act_high
      assign active = stage_q[STAGES-1];
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned PRE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf
);
   localparam int unsigned FULL_W = 2 * BYTE_W;

   if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
      $error("tmr_count_core: PRE_W must lie in 1..BYTE_W-1");
   end

   logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
   logic [FULL_W-1:0] cat_inc;

   assign cat_inc = {hi_q, lo_q} + 1'b1;

   always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      ovf  = 1'b0;
      if (wr_lo || wr_hi) begin
         if (wr_lo) lo_d = wdata;
         if (wr_hi) hi_d = wdata;
      end else if (step) begin
         unique case (mode)
            TM_PRESCALED: begin
               if (&lo_q[PRE_W-1:0]) begin
                  lo_d[PRE_W-1:0] = '0;
                  hi_d            = hi_q + 1'b1;
                  ovf             = &hi_q;
               end else begin
                  lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
               end
            end
            TM_CASCADE: begin
               {hi_d, lo_d} = cat_inc;
               ovf          = &{hi_q, lo_q};
            end
            TM_RELOAD: begin
               if (&lo_q) begin
                  lo_d = hi_q;
                  ovf  = 1'b1;
               end else begin
                  lo_d = lo_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   assign lo = lo_q;
   assign hi = hi_q;

   // R5: halt mode freezes the count unless software writes it
   p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_HALT && !wr_lo && !wr_hi) |=> $stable({hi_q, lo_q}));

   // R4: in reload mode only software changes the high byte
   p_reload_keeps_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD && !wr_hi) |=> $stable(hi_q));

   // R2: prescaled mode leaves the upper low-byte bits alone
   p_presc_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_PRESCALED && !wr_lo) |=> (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));

   // R10: a write to the low byte loads the written value
   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo_q == $past(wdata)));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic ack,
   input  logic ie,
   input  logic ea,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hw_set) flag_q <= 1'b1;
      else if (sw_wr)  flag_q <= sw_val;
      else if (ack)    flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & ie & ea;

   // R11: a hardware set beats any software value
   p_hw_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag_q);

   // R8: acknowledge clears the flag when nothing else touches it
   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !hw_set && !sw_wr) |=> !flag_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned PRE_W       = 5,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate_n,
   input  logic              vec_ack,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              irq
);
   if (BYTE_W < 8) begin : g_bad_byte
      $error("tmr_unit: BYTE_W must be at least 8 to hold the control byte");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("tmr_unit: ADDR_W must be at least 2");
   end

   logic      wr_lo, wr_hi, wr_ctl;
   tmr_mode_e mode_q;
   logic      run_q, gate_q, ie_q, ea_q;
   logic      gate_act, cnt_en, step, ovf, flag;
   logic [BYTE_W-1:0] lo, hi, ctl_rd;

   assign wr_lo  = wr_en && (addr == ADDR_W'(RA_LOW));
   assign wr_hi  = wr_en && (addr == ADDR_W'(RA_HIGH));
   assign wr_ctl = wr_en && (addr == ADDR_W'(RA_CTL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= TM_PRESCALED;
         run_q  <= 1'b0;
         gate_q <= 1'b0;
         ie_q   <= 1'b0;
         ea_q   <= 1'b0;
      end else if (wr_ctl) begin
         mode_q <= tmr_mode_e'(wdata[CB_MODE +: 2]);
         run_q  <= wdata[CB_RUN];
         gate_q <= wdata[CB_GATE];
         ie_q   <= wdata[CB_IE];
         ea_q   <= wdata[CB_EA];
      end
   end

   tmr_gate_sync #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(gate_n), .active(gate_act)
   );

   assign cnt_en = run_q && (!gate_q || gate_act) && (mode_q != TM_HALT);
   assign step   = tick && cnt_en;

   tmr_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .step(step),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
      .lo(lo), .hi(hi), .ovf(ovf)
   );

   tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(ovf), .sw_wr(wr_ctl),
      .sw_val(wdata[CB_FLAG]), .ack(vec_ack), .ie(ie_q), .ea(ea_q),
      .flag(flag), .irq(irq)
   );

   always_comb begin
      ctl_rd              = '0;
      ctl_rd[CB_MODE +: 2] = mode_q;
      ctl_rd[CB_RUN]      = run_q;
      ctl_rd[CB_GATE]     = gate_q;
      ctl_rd[CB_FLAG]     = flag;
      ctl_rd[CB_IE]       = ie_q;
      ctl_rd[CB_EA]       = ea_q;
   end

   always_comb begin
      unique case (addr)
         ADDR_W'(RA_LOW):  rdata = lo;
         ADDR_W'(RA_HIGH): rdata = hi;
         ADDR_W'(RA_CTL):  rdata = ctl_rd;
         default:          rdata = '0;
      endcase
   end

   // R7: without a strobe or a byte write the count stays put
   p_idle_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

   // R6: gating on with the pin inactive blocks counting
   p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && !gate_act && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

   // R9: no request while the global enable is off
   p_irq_needs_ea_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ea_q |-> !irq);
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, gate_n = 1'b1, vec_ack = 1'b0, wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int    n_chk = 0, n_err = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   tmr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate_n(gate_n), .vec_ack(vec_ack),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // behavioural reference model
   int m_lo, m_hi, m_mode, m_run, m_gate, m_flag, m_ie, m_ea, m_s1, m_s2;

   always @(posedge clk) begin
      int en, ovf, wcnt, c16;
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_mode = 0; m_run = 0; m_gate = 0;
         m_flag = 0; m_ie = 0; m_ea = 0; m_s1 = 1; m_s2 = 1;
      end else begin
         ovf  = 0;
         wcnt = (wr_en && (addr == 0 || addr == 1)) ? 1 : 0;
         en   = (m_run != 0 && (m_gate == 0 || m_s2 == 0) && m_mode != 3) ? 1 : 0;
         if (tick && en != 0 && wcnt == 0) begin
            if (m_mode == 0) begin
               if (m_lo % 32 == 31) begin
                  m_lo = m_lo - 31;
                  if (m_hi == 255) ovf = 1;
                  m_hi = (m_hi + 1) % 256;
               end else m_lo = m_lo + 1;
            end else if (m_mode == 1) begin
               c16 = m_hi * 256 + m_lo + 1;
               if (c16 == 65536) begin ovf = 1; c16 = 0; end
               m_hi = c16 / 256; m_lo = c16 % 256;
            end else begin
               if (m_lo == 255) begin m_lo = m_hi; ovf = 1; end
               else m_lo = m_lo + 1;
            end
         end
         if (wr_en && addr == 0) m_lo = int'(wdata);
         if (wr_en && addr == 1) m_hi = int'(wdata);
         if (wr_en && addr == 2) begin
            m_mode = int'(wdata[1:0]); m_run = int'(wdata[2]); m_gate = int'(wdata[3]);
            m_ie = int'(wdata[5]); m_ea = int'(wdata[6]);
         end
         if (ovf != 0) m_flag = 1;
         else if (wr_en && addr == 2) m_flag = int'(wdata[4]);
         else if (vec_ack) m_flag = 0;
         m_s2 = m_s1; m_s1 = int'(gate_n);
      end
   end

   function automatic int m_read(int a);
      if (a == 0) return m_lo;
      if (a == 1) return m_hi;
      if (a == 2) return m_mode + 4*m_run + 8*m_gate + 16*m_flag + 32*m_ie + 64*m_ea;
      return 0;
   endfunction

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         check({cur_tag, " model rdata"}, int'(rdata), m_read(int'(addr)));
         check({cur_tag, " model irq"}, int'(irq), m_flag * m_ie * m_ea);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk); wr_en = 1'b1; addr = 2'(a); wdata = 8'(d);
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tick_n(int n);
      repeat (n) begin @(negedge clk); tick = 1'b1; end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic rd_chk(string tag, int a, int exp);
      addr = 2'(a); #1;
      check(tag, int'(rdata), exp);
   endtask

   task automatic irq_chk(string tag, int exp);
      #1; check(tag, int'(irq), exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R1";
      rd_chk("R1 low", 0, 0); rd_chk("R1 high", 1, 0); rd_chk("R1 ctl", 2, 0);
      irq_chk("R1 irq", 0);

      cur_tag = "R12";
      wr(2, 8'h68); rd_chk("R12 ctl readback", 2, 8'h68);
      wr(2, 8'hFF); rd_chk("R12 bit7 reads 0", 2, 8'h7F);
      cur_tag = "R9";
      irq_chk("R9 irq all set", 1);
      wr(2, 8'h00); irq_chk("R9 irq flag clear", 0);
      cur_tag = "R12";
      wr(3, 8'hAA);
      rd_chk("R12 addr3 zero", 3, 0); rd_chk("R12 addr3 ignored low", 0, 0);
      rd_chk("R12 addr3 ignored high", 1, 0); rd_chk("R12 addr3 ignored ctl", 2, 0);

      cur_tag = "R3";
      wr(0, 8'hFE); wr(1, 8'hFF); wr(2, 8'h05);
      tick_n(1);
      rd_chk("R3 low FF", 0, 8'hFF); rd_chk("R3 high FF", 1, 8'hFF); rd_chk("R3 no flag", 2, 8'h05);
      tick_n(1);
      rd_chk("R3 wrap low", 0, 0); rd_chk("R3 wrap high", 1, 0);
      cur_tag = "R8";
      rd_chk("R8 flag set", 2, 8'h15);
      cur_tag = "R9";
      irq_chk("R9 no enables", 0);
      wr(2, 8'h35); irq_chk("R9 ie only", 0);
      wr(2, 8'h75); irq_chk("R9 ie and ea", 1);
      cur_tag = "R8";
      @(negedge clk); vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
      rd_chk("R8 ack clears", 2, 8'h65); irq_chk("R8 irq dropped", 0);

      cur_tag = "R2";
      wr(2, 8'h00); wr(0, 8'hFE); wr(1, 8'h05); wr(2, 8'h04);
      tick_n(2);
      rd_chk("R2 presc wrap low", 0, 8'hE0); rd_chk("R2 presc carry high", 1, 8'h06);
      wr(2, 8'h00); wr(0, 8'h9F); wr(1, 8'hFF); wr(2, 8'h04);
      tick_n(1);
      rd_chk("R2 13b wrap low", 0, 8'h80); rd_chk("R2 13b wrap high", 1, 0);
      rd_chk("R2 13b flag", 2, 8'h14);

      cur_tag = "R4";
      wr(2, 8'h00); wr(1, 8'h80); wr(0, 8'hFE); wr(2, 8'h06);
      tick_n(1);
      rd_chk("R4 low FF", 0, 8'hFF);
      cur_tag = "R11";
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 8'h06;
      @(negedge clk); tick = 1'b0; wr_en = 1'b0;
      rd_chk("R4 reload low", 0, 8'h80); rd_chk("R4 high kept", 1, 8'h80);
      rd_chk("R11 hw set beats sw clear", 2, 8'h16);
      wr(2, 8'h02); rd_chk("R11 sw clear", 2, 8'h02);
      wr(2, 8'h12); rd_chk("R11 sw set", 2, 8'h12);

      cur_tag = "R5";
      wr(2, 8'h07);
      tick_n(5);
      rd_chk("R5 halt low", 0, 8'h80); rd_chk("R5 halt high", 1, 8'h80);

      cur_tag = "R7";
      wr(2, 8'h01); wr(0, 8'h10); wr(1, 8'h00);
      tick_n(4); rd_chk("R7 run off", 0, 8'h10);
      wr(2, 8'h05);
      tick_n(4); rd_chk("R7 four strobes", 0, 8'h14);

      cur_tag = "R10";
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
      @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 8'h33;
      @(negedge clk); tick = 1'b0; wr_en = 1'b0;
      rd_chk("R10 low written", 0, 8'h40); rd_chk("R10 high written", 1, 8'h33);

      cur_tag = "R6";
      wr(2, 8'h0D);
      tick_n(3); rd_chk("R6 pin high blocks", 0, 8'h40);
      @(negedge clk); gate_n = 1'b0; tick = 1'b1;
      repeat (2) @(negedge clk);
      tick = 1'b0;
      rd_chk("R6 sync delay", 0, 8'h40);
      tick_n(1); rd_chk("R6 pin low counts", 0, 8'h41);
      @(negedge clk); gate_n = 1'b1;
      wr(2, 8'h05);
      tick_n(1); rd_chk("R6 gate off run only", 0, 8'h42);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule